// File: doc/BRIEF.md
# Random Word Output Buffer with Status and Interrupt

This block sits between a random word generator and a register bus. It collects generated words into a four-entry output buffer. Once the buffer is full and a minimum refill interval has passed, it raises a ready flag. Software reads the four words and then writes 1 to the ready flag. That write empties the buffer and asks the generator for a fresh set of words.

A status register collects health events, and every status bit is cleared by writing 1 to it. Most events arrive on an input from the generator's own tests. One event is computed here: a stuck output, which is flagged when two consecutive generated words are equal. A control register holds the global enable and one interrupt enable per event. A level interrupt is the OR of the enabled events.

A configuration register holds the minimum and maximum refill cycle counts. A read-only revision register reports major, minor and patch numbers, which are set by parameters.

Top module: `rng_outbuf`

## Requirements
- R1: After reset, status reads 0, control reads 0, configuration reads the parameter defaults (maximum in bits 31:16, minimum in bits 7:0), and both irq and gen_req are 0.
- R2: The four buffered words read back at byte offsets 0x00, 0x04, 0x08 and 0x0C, in the order the generator delivered them.
- R3: Generator words are captured only while the enable bit (control bit 10) is 1. Status bit 0 (ready) sets once four words have been captured.
- R4: Writing to status (offset 0x10) clears each bit written as 1 and leaves each bit written as 0. If an event arrives in the same cycle as the clear, the event wins and the bit stays set.
- R5: Clearing ready discards the buffer's fill state, so the next four words replace the old contents. gen_req is 1 only while the block is enabled, ready is 0, and fewer than four words have been captured.
- R6: While ready is set, generator words are ignored and the buffered words do not change.
- R7: Ready sets no earlier than the minimum refill count (configuration bits 7:0) of clock cycles after ready was cleared, even if all four words arrived sooner.
- R8: Status bit 2 sets when a valid word delivered while the block is enabled equals the previous such word.
- R9: A pulse on alarm_evt[k] sets status bit k, for k = 1 and 3 to 7.
- R10: irq is the OR over bits 7..1 of the status register, each ANDed with control bit k. Ready (status bit 0) never raises irq.
- R11: Configuration (offset 0x18) stores bits 31:16 and 7:0, and its other bits read 0. Control (offset 0x14) stores bits 10 and 7..1, and its other bits read 0.
- R12: Offset 0x7C reads the major, minor and patch numbers in bits 27:24, 23:20 and 19:16, with 0 elsewhere. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| gen_word | input | 32 | Generated word |
| gen_valid | input | 1 | gen_word is valid this cycle |
| gen_req | output | 1 | Buffer wants more words |
| alarm_evt | input | 7 | Health event pulses for status bits 7..1 |
| irq | output | 1 | Level interrupt |

## Verification
The bench sets the default minimum refill count to 3 so that ordinary fills complete within a few cycles. It then programs a minimum of 40 at run time, which makes the refill delay longer than the time taken to deliver four words, so R7 can be measured as a cycle count. The default maximum refill is set to 200, and the revision parameters are set to 5, 3 and 9. These are non-zero, distinct values, so the reset value of the configuration register and the field positions of the revision register are both visible at the port.

// File: rtl/rng_outbuf_pkg.sv
package rng_outbuf_pkg;
  localparam int OFS_STAT = 'h10;
  localparam int OFS_CTRL = 'h14;
  localparam int OFS_CFG  = 'h18;
  localparam int OFS_REV  = 'h7C;
  localparam int EN_BIT   = 10;

  function automatic logic irq_reduce(logic [7:0] st, logic [7:1] msk);
    return |(st[7:1] & msk);
  endfunction

  function automatic logic [31:0] pack_ctrl(logic en, logic [7:1] msk);
    return {21'h0, en, 2'b00, msk, 1'b0};
  endfunction

  function automatic logic [31:0] pack_cfg(logic [15:0] mx, logic [7:0] mn);
    return {mx, 8'h00, mn};
  endfunction

  function automatic logic [31:0] pack_rev(logic [3:0] ma, logic [3:0] mi, logic [3:0] pa);
    return {4'h0, ma, mi, pa, 16'h0000};
  endfunction
endpackage

// File: rtl/rob_fill_ctrl.sv
module rob_fill_ctrl #(
  parameter int WORDS = 4,
  localparam int IDX_W = $clog2(WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ready,
  input  logic             restart,
  input  logic             gen_valid,
  input  logic [7:0]       min_cyc,
  output logic             accept,
  output logic [IDX_W-1:0] wr_idx,
  output logic             set_ready,
  output logic             gen_req
);
  logic [IDX_W-1:0] fill_q;
  logic [7:0]       cyc_q;
  logic             full;

  assign full      = (fill_q == IDX_W'(WORDS));
  assign accept    = gen_valid && en && !ready && !full;
  assign wr_idx    = fill_q;
  assign set_ready = en && !ready && full && (cyc_q >= min_cyc);
  assign gen_req   = en && !ready && !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_q <= '0;
      cyc_q  <= '0;
    end else if (restart) begin
      fill_q <= '0;
      cyc_q  <= '0;
    end else begin
      if (accept) fill_q <= fill_q + IDX_W'(1);
      if (en && !ready && cyc_q != 8'hFF) cyc_q <= cyc_q + 8'd1;
    end
  end

  // R5: a restart leaves the buffer empty on the next cycle
  a_r5_restart_empties: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (fill_q == '0) && !full);
endmodule

// File: rtl/rob_stuck_det.sv
module rob_stuck_det #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         valid,
  input  logic [W-1:0] word,
  output logic         hit
);
  logic [W-1:0] prev_q;
  logic         have_q;

  assign hit = en && valid && have_q && (word == prev_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      have_q <= 1'b0;
    end else if (en && valid) begin
      prev_q <= word;
      have_q <= 1'b1;
    end
  end

  // R8: the comparison reference follows the last delivered word
  a_r8_prev_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (en && valid) |=> (prev_q == $past(word)) && have_q);
endmodule

// File: rtl/rob_status.sv
module rob_status #(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] set_mask,
  input  logic [SW-1:0] clr_mask,
  output logic [SW-1:0] st
);
  always_ff @(posedge clk) begin
    if (!rst_n) st <= '0;
    else        st <= (st & ~clr_mask) | set_mask;
  end

  for (genvar b = 0; b < SW; b++) begin : g_chk
    // R4: a clear without a same-cycle event drops the bit
    a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask[b] && !set_mask[b]) |=> !st[b]);
    // R4: an event always lands, even against a clear
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_mask[b] |=> st[b]);
  end
endmodule

// File: rtl/rng_outbuf.sv
module rng_outbuf
  import rng_outbuf_pkg::*;
#(
  parameter int          ADDR_W         = 8,
  parameter int          WORDS          = 4,
  parameter int          DEF_MIN_REFILL = 10,
  parameter int          DEF_MAX_REFILL = 10,
  parameter logic [3:0]  REV_MAJOR      = 4'd1,
  parameter logic [3:0]  REV_MINOR      = 4'd0,
  parameter logic [3:0]  REV_PATCH      = 4'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [31:0]       gen_word,
  input  logic              gen_valid,
  output logic              gen_req,
  input  logic [7:1]        alarm_evt,
  output logic              irq
);
  localparam int IDX_W  = $clog2(WORDS + 1);
  localparam int WIDX_W = $clog2(WORDS);

  logic [31:0]      word_q [WORDS];
  logic             en_q;
  logic [7:1]       msk_q;
  logic [15:0]      max_q;
  logic [7:0]       min_q;
  logic [7:0]       st;
  logic [7:0]       set_mask, clr_mask;
  logic             wr_stat, wr_ctrl, wr_cfg;
  logic             ready_clr, accept, set_ready, stuck_hit;
  logic [IDX_W-1:0] wr_idx;
  logic             unused_wdata;

  assign wr_stat   = reg_wr && (reg_addr == ADDR_W'(OFS_STAT));
  assign wr_ctrl   = reg_wr && (reg_addr == ADDR_W'(OFS_CTRL));
  assign wr_cfg    = reg_wr && (reg_addr == ADDR_W'(OFS_CFG));
  assign clr_mask  = wr_stat ? reg_wdata[7:0] : 8'h00;
  assign ready_clr = clr_mask[0] && st[0];
  assign set_mask  = {alarm_evt[7:3], alarm_evt[2] | stuck_hit, alarm_evt[1], set_ready};
  assign irq       = irq_reduce(st, msk_q);
  assign unused_wdata = ^{reg_wdata[15:11], reg_wdata[9:8]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      msk_q <= '0;
      max_q <= 16'(DEF_MAX_REFILL);
      min_q <= 8'(DEF_MIN_REFILL);
    end else begin
      if (wr_ctrl) begin
        en_q  <= reg_wdata[EN_BIT];
        msk_q <= reg_wdata[7:1];
      end
      if (wr_cfg) begin
        max_q <= reg_wdata[31:16];
        min_q <= reg_wdata[7:0];
      end
    end
  end

  rob_fill_ctrl #(.WORDS(WORDS)) u_fill (
    .clk(clk), .rst_n(rst_n), .en(en_q), .ready(st[0]), .restart(ready_clr),
    .gen_valid(gen_valid), .min_cyc(min_q), .accept(accept), .wr_idx(wr_idx),
    .set_ready(set_ready), .gen_req(gen_req)
  );

  rob_stuck_det #(.W(32)) u_stuck (
    .clk(clk), .rst_n(rst_n), .en(en_q), .valid(gen_valid), .word(gen_word),
    .hit(stuck_hit)
  );

  rob_status #(.SW(8)) u_status (
    .clk(clk), .rst_n(rst_n), .set_mask(set_mask), .clr_mask(clr_mask), .st(st)
  );

  for (genvar k = 0; k < WORDS; k++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)                              word_q[k] <= '0;
      else if (accept && wr_idx == IDX_W'(k))  word_q[k] <= gen_word;
    end
    // R6: buffered words hold while ready stays set
    a_r6_words_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st[0] && !ready_clr) |=> $stable(word_q[k]));
  end

  always_comb begin
    reg_rdata = 32'h0;
    if (reg_addr < ADDR_W'(WORDS * 4))        reg_rdata = word_q[reg_addr[WIDX_W+1:2]];
    else if (reg_addr == ADDR_W'(OFS_STAT))   reg_rdata = {24'h0, st};
    else if (reg_addr == ADDR_W'(OFS_CTRL))   reg_rdata = pack_ctrl(en_q, msk_q);
    else if (reg_addr == ADDR_W'(OFS_CFG))    reg_rdata = pack_cfg(max_q, min_q);
    else if (reg_addr == ADDR_W'(OFS_REV))    reg_rdata = pack_rev(REV_MAJOR, REV_MINOR, REV_PATCH);
  end

  // Checker counter: cycles spent with ready low since the last clear
  logic [15:0] gap_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                         gap_q <= '0;
    else if (ready_clr)                 gap_q <= '0;
    else if (!st[0] && gap_q != 16'hFFFF) gap_q <= gap_q + 16'd1;
  end

  // R7: ready never returns before the minimum refill interval
  a_r7_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st[0]) |-> (gap_q > {8'h00, min_q}));
  // R3: ready only rises after a cycle with the block enabled
  a_r3_ready_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st[0]) |-> $past(en_q));
  // R8: a stuck comparison hit lands in status bit 2
  a_r8_stuck_flag: assert property (@(posedge clk) disable iff (!rst_n)
    stuck_hit |=> st[2]);
  // R10: with no event pending, ready alone keeps irq low
  a_r10_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st[7:1] == 7'h0) |-> !irq);
  // R5: no request for words while the buffer is ready
  a_r5_no_req_ready: assert property (@(posedge clk) disable iff (!rst_n)
    st[0] |-> !gen_req);
endmodule

// File: tb/rng_outbuf_bench.sv
module rng_outbuf_bench;
  localparam real CLK_NS = 5.0;
  localparam int  A_STAT = 'h10, A_CTRL = 'h14, A_CFG = 'h18, A_REV = 'h7C;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [31:0] gen_word = '0;
  logic        gen_valid = 1'b0, gen_req, irq;
  logic [7:1]  alarm_evt = '0;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];

  always #(CLK_NS / 2) clk = ~clk;

  rng_outbuf #(.ADDR_W(8), .WORDS(4), .DEF_MIN_REFILL(3), .DEF_MAX_REFILL(200),
               .REV_MAJOR(4'd5), .REV_MINOR(4'd3), .REV_PATCH(4'd9)) u_rng_outbuf (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gen_word(gen_word),
    .gen_valid(gen_valid), .gen_req(gen_req), .alarm_evt(alarm_evt), .irq(irq));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic reg_write(int a, logic [31:0] d);
    @(negedge clk); reg_addr = 8'(a); reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(int a, output logic [31:0] v);
    @(negedge clk); reg_addr = 8'(a); #1; v = reg_rdata;
  endtask

  // Driver: presents a word and queues it when the buffer should take it
  task automatic push_word(logic [31:0] w, bit expect_take);
    @(negedge clk); gen_valid = 1'b1; gen_word = w;
    if (expect_take) exp_q.push_back(w);
    @(negedge clk); gen_valid = 1'b0;
  endtask

  task automatic wait_ready(int limit, output int polls);
    logic [31:0] s;
    polls = 0;
    s = '0;
    while (polls < limit && !s[0]) begin reg_read(A_STAT, s); polls++; end
  endtask

  // Monitor: pops expected words and compares buffer contents
  task automatic check_fill(string tag);
    logic [31:0] v;
    for (int k = 0; k < 4; k++) begin
      reg_read(k * 4, v);
      if (exp_q.size() > 0) check(tag, v, exp_q.pop_front());
      else check({tag, " queue empty"}, 32'h1, 32'h0);
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] held [4];
    int polls;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_read(A_STAT, v); check("R1 status", v, 32'h0);
    reg_read(A_CTRL, v); check("R1 control", v, 32'h0);
    reg_read(A_CFG, v);  check("R1 config", v, 32'h00C8_0003);
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 gen_req", {31'h0, gen_req}, 32'h0);

    // R12 revision and unmapped
    reg_read(A_REV, v); check("R12 revision", v, 32'h0539_0000);
    reg_read('h40, v);  check("R12 unmapped", v, 32'h0);

    // R3 disabled: words ignored, no stuck detection
    push_word(32'hDEAD_0001, 1'b0);
    push_word(32'hDEAD_0001, 1'b0);
    reg_read(0, v);      check("R3 disabled word0", v, 32'h0);
    reg_read(A_STAT, v); check("R3 disabled status", v, 32'h0);

    // R3/R5 enable and fill
    reg_write(A_CTRL, 32'h0000_0400);
    check("R5 gen_req enabled", {31'h0, gen_req}, 32'h1);
    push_word(32'h1234_5678, 1'b1);
    push_word(32'h9ABC_DEF0, 1'b1);
    push_word(32'h0F0F_0F0F, 1'b1);
    push_word(32'hA5A5_5A5A, 1'b1);
    wait_ready(50, polls);
    reg_read(A_STAT, v); check("R3 ready set", v, 32'h1);
    check("R5 gen_req ready", {31'h0, gen_req}, 32'h0);
    check_fill("R2 word order");

    // R6 words ignored while ready
    for (int k = 0; k < 4; k++) begin reg_read(k * 4, v); held[k] = v; end
    push_word(32'h7777_0001, 1'b0);
    push_word(32'h7777_0002, 1'b0);
    for (int k = 0; k < 4; k++) begin reg_read(k * 4, v); check("R6 word held", v, held[k]); end

    // R4 write 0 keeps, write 1 clears
    reg_write(A_STAT, 32'h0);
    reg_read(A_STAT, v); check("R4 write zero keeps", v, 32'h1);
    reg_write(A_CFG, 32'h00C8_0028);
    reg_write(A_STAT, 32'h1);
    // R7 min refill 40 cycles: elapsed counted in negedges since clear
    push_word(32'h1111_0001, 1'b1);
    push_word(32'h1111_0002, 1'b1);
    push_word(32'h1111_0003, 1'b1);
    push_word(32'h1111_0004, 1'b1);
    reg_read(A_STAT, v); check("R7 not ready early", v, 32'h0);
    check("R5 gen_req full", {31'h0, gen_req}, 32'h0);
    wait_ready(80, polls);
    check("R7 elapsed lower", {31'h0, (polls + 9) >= 38}, 32'h1);
    check("R7 elapsed upper", {31'h0, (polls + 9) <= 44}, 32'h1);
    check_fill("R5 refill replaces");

    // R8 stuck detection, R10 masking
    reg_write(A_CFG, 32'h00C8_0003);
    reg_write(A_STAT, 32'h1);
    push_word(32'h2222_AAAA, 1'b1);
    push_word(32'h2222_AAAA, 1'b1);
    reg_read(A_STAT, v); check("R8 stuck bit", v, 32'h4);
    check("R10 irq masked", {31'h0, irq}, 32'h0);
    reg_write(A_CTRL, 32'h0000_0404);
    check("R10 irq unmasked", {31'h0, irq}, 32'h1);
    reg_write(A_STAT, 32'h4);
    check("R10 irq after clear", {31'h0, irq}, 32'h0);
    push_word(32'h3333_0001, 1'b1);
    push_word(32'h3333_0002, 1'b1);
    wait_ready(50, polls);
    check_fill("R8 fill with repeat");

    // R9 alarm event sets its bit
    @(negedge clk); alarm_evt = 7'b0010000;
    @(negedge clk); alarm_evt = '0;
    reg_read(A_STAT, v); check("R9 alarm bit5", v, 32'h21);
    check("R10 bit5 masked", {31'h0, irq}, 32'h0);
    reg_write(A_CTRL, 32'h0000_0420);
    check("R10 bit5 irq", {31'h0, irq}, 32'h1);
    reg_write(A_STAT, 32'h20);
    reg_write(A_CTRL, 32'h0000_04FE);
    reg_read(A_STAT, v); check("R10 only ready", v, 32'h1);
    check("R10 ready no irq", {31'h0, irq}, 32'h0);

    // R4 event wins over same-cycle clear
    @(negedge clk); reg_addr = 8'(A_STAT); reg_wr = 1'b1; reg_wdata = 32'h8; alarm_evt = 7'b0000100;
    @(negedge clk); reg_wr = 1'b0; alarm_evt = '0;
    reg_read(A_STAT, v); check("R4 set wins", v, 32'h9);
    check("R9 bit3 irq", {31'h0, irq}, 32'h1);
    reg_write(A_STAT, 32'h8);
    reg_read(A_STAT, v); check("R4 bit3 cleared", v, 32'h1);

    // R11 field storage
    reg_write(A_CFG, 32'hFFFF_FFFF);
    reg_read(A_CFG, v);  check("R11 config fields", v, 32'hFFFF_00FF);
    reg_write(A_CTRL, 32'hFFFF_FFFF);
    reg_read(A_CTRL, v); check("R11 control fields", v, 32'h0000_04FE);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule